// File: doc/BRIEF.md
# Multi-Channel Register-Programmed DMA Controller

This block moves data for a few independent channels. Each channel holds a source address, a destination address, a unit count and a control word. Software sets these through a small 32-bit register bus. A channel starts when its control word is written with the enable bit set and the done bit clear. The engine then copies one unit at a time over a single-beat memory port. Each unit is a read from the source followed by a write to the destination. A unit is 1, 2 or 4 bytes wide.

A global control word holds a master enable and two sticky fault flags. One flag is for a misaligned address and the other is for an external non-maskable event. While either flag is set no channel is served. Raising either flag also drops the enable bit of every channel, so software must clear the flag and re-enable each channel. Each channel has an end-of-transfer interrupt, and the controller has one fault interrupt. Channels that are ready are served in turn, one unit each, in round-robin order.

Top module: `mchan_dma`

## Requirements
- R1: After reset every channel register and the global word read 0, and `mem_req`, `ch_irq` and `err_irq` are low.
- R2: Channel k's registers are at byte offset k*0x10: +0x0 source, +0x4 destination, +0x8 count (24 bits; upper bits read 0), +0xC control. The global word is at 0x40 and holds bit0 master enable, bit1 event flag and bit2 alignment flag. A channel-clear word is at 0x44. Writing 1 to a flag bit cannot set it.
- R3: The control bits are: bit0 enable, bit1 done, bit2 interrupt enable, bits4:3 size-low, bit5 destination step, bit6 source step, bit7 peripheral pacing, bit8 size-high. The size index is {bit8, bits4:3}. Index 0, 1 and 2 give units of 1, 2 and 4 bytes, and any larger index acts as index 0 (1 byte).
- R4: Each unit reads the source and writes the destination on the matching byte lanes. A stepping address moves by the unit size and a fixed address stays put. The count drops by 1 per unit, so after N units a stepping address has moved N times the unit size.
- R5: A channel is busy while enable is 1 and done is 0. When the count reaches 0 the done bit is set and the enable bit stays 1.
- R6: `ch_irq[k]` is high exactly when channel k's done bit and interrupt-enable bit are both 1.
- R7: Writes to the source, destination or count of a busy channel are ignored.
- R8: No memory access is made while master enable is 0 or a flag is set. When two channels are ready, their units alternate.
- R9: A channel with pacing set moves a unit only while its `dreq` bit is high.
- R10: Serving a channel whose source or destination is not aligned to its unit size sets the alignment flag without accessing memory. It raises `err_irq` and clears the enable bit of every channel. Writing 0 to the flag clears it.
- R11: A high `nmi_in` sets the event flag and clears every channel's enable bit. If software writes 0 to the flag in the same cycle, the set takes priority.
- R12: Writing 1 to bit k of the channel-clear word zeroes all four registers of channel k and leaves the other channels unchanged.
- R13: A channel started with a count of 0 is marked done without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| dreq | input | NCH | Per-channel peripheral request level |
| nmi_in | input | 1 | External non-maskable event |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data, lane-aligned |
| mem_be | output | DW/8 | Write byte enables |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW | Read data, valid with ack |
| ch_irq | output | NCH | Per-channel end-of-transfer interrupt |
| err_irq | output | 1 | Alignment fault interrupt |

## Verification
Two functions can land on the same clock edge. The first is a software write to the global word that clears the event flag. The second is the event input raising that same flag. The bench holds `nmi_in` high through the cycle of a register write of 0 to the flag, then reads the global word back. The flag must still be set, and the running channel must have lost its enable bit and kept its count. A second check of the same kind lets one channel's misalignment fire while another channel is moving units. That channel must stop with its count partly used, and its count must not move again.

// File: rtl/mdma_pkg.sv
`timescale 1ns/1ps
package mdma_pkg;

   localparam int CTL_W = 9;

   typedef struct packed {
      logic       szh;
      logic       preq;
      logic       sinc;
      logic       dinc;
      logic [1:0] szl;
      logic       ie;
      logic       done;
      logic       en;
   } chan_ctl_t;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_READ  = 2'd1,
      ENG_WRITE = 2'd2
   } eng_state_t;

   // log2 of unit bytes; indices past the table fall back to entry 0
   function automatic logic [2:0] unit_log2(input logic [2:0] idx, input int nsize);
      return (int'(idx) < nsize) ? idx : 3'd0;
   endfunction

endpackage

// File: rtl/mdma_chan.sv
`timescale 1ns/1ps
module mdma_chan
   import mdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CW    = 24,
   parameter int NSIZE = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          kill,
   input  logic          wr,
   input  logic [1:0]    wsel,
   input  logic [31:0]   wdata,
   input  logic          step,
   input  logic          fin,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [CW-1:0] cnt,
   output chan_ctl_t     ctl,
   output logic          busy,
   output logic [2:0]    ulog2,
   output logic          irq
);

   assign busy  = ctl.en & ~ctl.done;
   assign ulog2 = unit_log2({ctl.szh, ctl.szl}, NSIZE);
   assign irq   = ctl.done & ctl.ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src <= '0;
         dst <= '0;
         cnt <= '0;
         ctl <= '0;
      end else if (clr) begin
         src <= '0;
         dst <= '0;
         cnt <= '0;
         ctl <= '0;
      end else begin
         if (wr && !busy) begin
            case (wsel)
               2'd0:    src <= wdata[AW-1:0];
               2'd1:    dst <= wdata[AW-1:0];
               2'd2:    cnt <= wdata[CW-1:0];
               default: ;
            endcase
         end
         if (wr && wsel == 2'd3)
            ctl <= chan_ctl_t'(wdata[CTL_W-1:0]);
         if (step) begin
            if (ctl.sinc) src <= src + (AW'(1) << ulog2);
            if (ctl.dinc) dst <= dst + (AW'(1) << ulog2);
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) ctl.done <= 1'b1;
         end
         if (fin)  ctl.done <= 1'b1;
         if (kill) ctl.en   <= 1'b0;
      end
   end

   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> cnt == $past(cnt) - CW'(1));

   assert_busy_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wsel == 2'd0 && busy && !step && !clr) |=> src == $past(src));

   assert_done_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == CW'(1) && !clr) |=> ctl.done);

endmodule

// File: rtl/mdma_arb.sv
`timescale 1ns/1ps
module mdma_arb #(
   parameter int N  = 2,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gidx,
   output logic          any
);

   logic [IW-1:0] ptr;

   always_comb begin
      gnt  = '0;
      gidx = '0;
      any  = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (!any && req[(int'(ptr) + k) % N]) begin
            any = 1'b1;
            gnt[(int'(ptr) + k) % N] = 1'b1;
            gidx = IW'((int'(ptr) + k) % N);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv && any)
         ptr <= (int'(gidx) == N - 1) ? '0 : gidx + IW'(1);
   end

   generate
      if (N > 1) begin : g_rr_chk
         assert_rr_rotates_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && any && (&req)) |=> (!(&req) || gidx != $past(gidx)));
      end
   endgenerate

endmodule

// File: rtl/mdma_engine.sv
`timescale 1ns/1ps
module mdma_engine
   import mdma_pkg::*;
#(
   parameter int N    = 2,
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int CW   = 24,
   parameter int IW   = 1,
   parameter int OFFW = $clog2(DW / 8),
   parameter int BEW  = DW / 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stop_all,
   input  logic [N-1:0]   busy,
   input  logic           any,
   input  logic [IW-1:0]  gidx,
   input  logic [AW-1:0]  src_a [N],
   input  logic [AW-1:0]  dst_a [N],
   input  logic [CW-1:0]  cnt_a [N],
   input  logic [2:0]     lg_a  [N],
   output logic           adv,
   output logic [N-1:0]   step,
   output logic [N-1:0]   fin,
   output logic           ae_set,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   output logic [BEW-1:0] mem_be,
   input  logic           mem_ack,
   input  logic [DW-1:0]  mem_rdata
);

   eng_state_t    st;
   logic [IW-1:0] cur;
   logic [DW-1:0] hold;
   logic [OFFW-1:0] amask;
   logic          misal, pick, zero, abort;
   logic [BEW-1:0] bmask;

   always_comb begin
      amask = OFFW'((32'd1 << lg_a[gidx]) - 32'd1);
      misal = |(src_a[gidx][OFFW-1:0] & amask) | |(dst_a[gidx][OFFW-1:0] & amask);
      for (int b = 0; b < BEW; b++)
         bmask[b] = (b < (1 << lg_a[cur]));
   end

   assign pick   = (st == ENG_IDLE) && any && !stop_all;
   assign zero   = (cnt_a[gidx] == '0);
   assign adv    = pick;
   assign ae_set = pick && !zero && misal;
   assign abort  = stop_all || !busy[cur];

   assign mem_req   = (st != ENG_IDLE) && !abort;
   assign mem_we    = (st == ENG_WRITE);
   assign mem_addr  = (st == ENG_WRITE) ? dst_a[cur] : src_a[cur];
   assign mem_wdata = hold << {dst_a[cur][OFFW-1:0], 3'b000};
   assign mem_be    = bmask << dst_a[cur][OFFW-1:0];

   always_comb begin
      step = '0;
      fin  = '0;
      if (st == ENG_WRITE && mem_req && mem_ack) step[cur] = 1'b1;
      if (pick && zero) fin[gidx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ENG_IDLE;
         cur  <= '0;
         hold <= '0;
      end else begin
         case (st)
            ENG_IDLE: if (pick && !zero && !misal) begin
               st  <= ENG_READ;
               cur <= gidx;
            end
            ENG_READ: if (abort) st <= ENG_IDLE;
               else if (mem_ack) begin
                  hold <= mem_rdata >> {src_a[cur][OFFW-1:0], 3'b000};
                  st   <= ENG_WRITE;
               end
            ENG_WRITE: if (abort || mem_ack) st <= ENG_IDLE;
            default: st <= ENG_IDLE;
         endcase
      end
   end

   assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ENG_WRITE) |-> $past(st) == ENG_READ || $past(st) == ENG_WRITE);

endmodule

// File: rtl/mchan_dma.sv
`timescale 1ns/1ps
module mchan_dma
   import mdma_pkg::*;
#(
   parameter int NCH = 2,
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int CW  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NCH-1:0]    dreq,
   input  logic              nmi_in,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   output logic [DW/8-1:0]   mem_be,
   input  logic              mem_ack,
   input  logic [DW-1:0]     mem_rdata,
   output logic [NCH-1:0]    ch_irq,
   output logic              err_irq
);

   localparam int OFFW  = $clog2(DW / 8);
   localparam int BEW   = DW / 8;
   localparam int NSIZE = OFFW + 1;
   localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("mchan_dma: NCH must be 1..4");
      end
      if (DW != 16 && DW != 32 && DW != 64) begin : g_bad_dw
         $error("mchan_dma: DW must be 16, 32 or 64");
      end
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("mchan_dma: AW must be 8..32");
      end
      if (CW < 1 || CW > 32) begin : g_bad_cw
         $error("mchan_dma: CW must be 1..32");
      end
   endgenerate

   logic men, nmif, aerr;
   logic stop_all, kill, ae_set, adv, any;
   logic [IW-1:0]  gidx;
   logic [NCH-1:0] busy_v, ready_v, gnt, step_v, fin_v;
   logic [AW-1:0]  src_a [NCH];
   logic [AW-1:0]  dst_a [NCH];
   logic [CW-1:0]  cnt_a [NCH];
   logic [2:0]     lg_a  [NCH];
   chan_ctl_t      ctl_a [NCH];

   wire g_sel   = (reg_addr == 8'h40);
   wire clr_sel = (reg_addr == 8'h44);

   assign stop_all = !men || nmif || aerr;
   assign kill     = nmi_in || ae_set;
   assign err_irq  = aerr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         men  <= 1'b0;
         nmif <= 1'b0;
         aerr <= 1'b0;
      end else begin
         if (reg_wr && g_sel) begin
            men  <= reg_wdata[0];
            nmif <= nmif & reg_wdata[1];
            aerr <= aerr & reg_wdata[2];
         end
         if (nmi_in) nmif <= 1'b1;
         if (ae_set) aerr <= 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         wire ch_wr = reg_wr && reg_addr[7:6] == 2'b00 &&
                      reg_addr[5:4] == 2'(g) && reg_addr[1:0] == 2'b00;
         mdma_chan #(.AW(AW), .CW(CW), .NSIZE(NSIZE)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (reg_wr && clr_sel && reg_wdata[g]),
            .kill  (kill),
            .wr    (ch_wr),
            .wsel  (reg_addr[3:2]),
            .wdata (reg_wdata),
            .step  (step_v[g]),
            .fin   (fin_v[g]),
            .src   (src_a[g]),
            .dst   (dst_a[g]),
            .cnt   (cnt_a[g]),
            .ctl   (ctl_a[g]),
            .busy  (busy_v[g]),
            .ulog2 (lg_a[g]),
            .irq   (ch_irq[g])
         );
         assign ready_v[g] = busy_v[g] & (~ctl_a[g].preq | dreq[g]);
      end
   endgenerate

   mdma_arb #(.N(NCH), .IW(IW)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ready_v),
      .adv   (adv),
      .gnt   (gnt),
      .gidx  (gidx),
      .any   (any)
   );

   mdma_engine #(.N(NCH), .AW(AW), .DW(DW), .CW(CW), .IW(IW),
                 .OFFW(OFFW), .BEW(BEW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_all  (stop_all),
      .busy      (busy_v),
      .any       (any),
      .gidx      (gidx),
      .src_a     (src_a),
      .dst_a     (dst_a),
      .cnt_a     (cnt_a),
      .lg_a      (lg_a),
      .adv       (adv),
      .step      (step_v),
      .fin       (fin_v),
      .ae_set    (ae_set),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_be    (mem_be),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   always_comb begin
      reg_rdata = '0;
      if (g_sel) reg_rdata = {29'd0, aerr, nmif, men};
      for (int g = 0; g < NCH; g++) begin
         if (reg_addr[7:6] == 2'b00 && reg_addr[5:4] == 2'(g) && reg_addr[1:0] == 2'b00) begin
            case (reg_addr[3:2])
               2'd0:    reg_rdata = 32'(src_a[g]);
               2'd1:    reg_rdata = 32'(dst_a[g]);
               2'd2:    reg_rdata = 32'(cnt_a[g]);
               default: reg_rdata = 32'(ctl_a[g]);
            endcase
         end
      end
   end

   assert_ae_halts_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ae_set |=> (busy_v == '0));

   assert_nmi_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_in |=> nmif);

   assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!men || nmif || aerr) |-> !mem_req);

   assert_grant_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

endmodule

// File: tb/sim_mchan_dma.sv
`timescale 1ns/1ps
module sim_mchan_dma;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  dreq = '0;
   logic        nmi_in = 1'b0;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic [1:0]  ch_irq;
   logic        err_irq;

   logic [7:0] mem  [256];
   logic [7:0] wlog [256];
   int unsigned wn = 0;
   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   mchan_dma u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .nmi_in(nmi_in),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .ch_irq(ch_irq), .err_irq(err_irq)
   );

   wire [7:0] wa = {mem_addr[7:2], 2'b00};
   assign mem_ack   = mem_req;
   assign mem_rdata = {mem[wa + 8'd3], mem[wa + 8'd2], mem[wa + 8'd1], mem[wa]};

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[wa + 8'(b)] <= mem_wdata[8*b +: 8];
         wlog[wn[7:0]] <= mem_addr[7:0];
         wn <= wn + 1;
      end
   end

   function automatic logic [7:0] pat(input int i);
      return 8'(i * 7 + 3);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_irq(input int ch);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (ch_irq[ch]) break;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(8'h40, d); chk("R1 global", d, 32'h0);
      rd(8'h0C, d); chk("R1 ctl0", d, 32'h0);
      rd(8'h10, d); chk("R1 src1", d, 32'h0);
      chk("R1 outputs", {mem_req, ch_irq, err_irq}, 4'b0000);
   endtask

   task automatic t_regmap;
      logic [31:0] d;
      wr(8'h14, 32'h1234_5678); rd(8'h14, d); chk("R2 dst1", d, 32'h1234_5678);
      wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d); chk("R2 cnt1 24b", d, 32'h00FF_FFFF);
      wr(8'h40, 32'h7);         rd(8'h40, d); chk("R2 flags not settable", d, 32'h1);
   endtask

   task automatic t_copy;
      logic [31:0] d;
      int bad;
      wr(8'h00, 32'h00); wr(8'h04, 32'h80); wr(8'h08, 4);
      wr(8'h0C, 32'h75);
      wr(8'h00, 32'h40);                       // ignored: busy (R7)
      wait_irq(0);
      bad = 0;
      for (int i = 0; i < 16; i++) if (mem[8'h80 + i] !== pat(i)) bad++;
      chk("R4 copied bytes mismatches", bad, 0);
      rd(8'h00, d); chk("R7 src after busy write", d, 32'h10);
      rd(8'h04, d); chk("R4 dst advanced", d, 32'h90);
      rd(8'h08, d); chk("R4 count zero", d, 0);
      rd(8'h0C, d); chk("R5 done en kept", d, 32'h77);
      chk("R6 irq on", ch_irq[0], 1'b1);
      wr(8'h0C, 32'h73);
      #1 chk("R6 irq off with ie=0", ch_irq[0], 1'b0);
   endtask

   task automatic t_size;
      logic [31:0] d;
      wr(8'h00, 32'h20); wr(8'h04, 32'hA0); wr(8'h08, 3); wr(8'h0C, 32'h7D);
      wait_irq(0);
      rd(8'h00, d); chk("R3 index3 as byte", d, 32'h23);
      chk("R3 byte data", {mem[8'hA0], mem[8'hA1], mem[8'hA2], mem[8'hA3]},
          {pat(32), pat(33), pat(34), 8'h00});
      wr(8'h00, 32'h24); wr(8'h04, 32'hA4); wr(8'h08, 2); wr(8'h0C, 32'h16D);
      wait_irq(0);
      rd(8'h00, d); chk("R3 index5 as byte", d, 32'h26);
      wr(8'h00, 32'h30); wr(8'h04, 32'hB0); wr(8'h08, 2); wr(8'h0C, 32'h6D);
      wait_irq(0);
      rd(8'h00, d); chk("R3 halfword step", d, 32'h34);
      chk("R3 halfword data", {mem[8'hB0], mem[8'hB3]}, {pat(48), pat(51)});
      wr(8'h00, 32'h38); wr(8'h04, 32'hB8); wr(8'h08, 2); wr(8'h0C, 32'h4D);
      wait_irq(0);
      rd(8'h04, d); chk("R4 fixed dst", d, 32'hB8);
      chk("R4 fixed dst last unit", {mem[8'hB8], mem[8'hB9]}, {pat(58), pat(59)});
   endtask

   task automatic t_rr;
      int base, bad;
      wr(8'h40, 32'h0);
      wr(8'h00, 32'h00); wr(8'h04, 32'hC0); wr(8'h08, 3); wr(8'h0C, 32'h75);
      wr(8'h10, 32'h40); wr(8'h14, 32'hE0); wr(8'h18, 3); wr(8'h1C, 32'h75);
      base = wn;
      idle(6);
      chk("R8 no access with master off", wn - base, 0);
      wr(8'h40, 32'h1);
      wait_irq(0); wait_irq(1);
      bad = 0;
      for (int k = 0; k < 5; k++)
         if ((wlog[8'(base + k)] >= 8'hE0) == (wlog[8'(base + k + 1)] >= 8'hE0)) bad++;
      chk("R8 alternation breaks", bad, 0);
      chk("R8 write count", wn - base, 6);
   endtask

   task automatic t_preq;
      logic [31:0] d;
      wr(8'h10, 32'h50); wr(8'h14, 32'hD0); wr(8'h18, 2); wr(8'h1C, 32'hF5);
      idle(10);
      rd(8'h18, d); chk("R9 held without dreq", d, 2);
      dreq = 2'b10;
      wait_irq(1);
      dreq = 2'b00;
      rd(8'h18, d); chk("R9 done with dreq", d, 0);
   endtask

   task automatic t_zero;
      logic [31:0] d;
      int base;
      base = wn;
      wr(8'h08, 0); wr(8'h0C, 32'h75);
      idle(5);
      rd(8'h0C, d); chk("R13 zero count done", d, 32'h77);
      chk("R13 no memory write", wn - base, 0);
   endtask

   task automatic t_aerr;
      logic [31:0] d, c1;
      wr(8'h10, 32'h00); wr(8'h14, 32'hFC); wr(8'h18, 100); wr(8'h1C, 32'h15);
      wr(8'h00, 32'h02); wr(8'h04, 32'h90); wr(8'h08, 1); wr(8'h0C, 32'h75);
      idle(6);
      chk("R10 err_irq", err_irq, 1'b1);
      rd(8'h40, d);  chk("R10 flag set", d, 32'h5);
      rd(8'h1C, d);  chk("R10 other channel stopped", d, 32'h14);
      rd(8'h0C, d);  chk("R10 faulting channel stopped", d, 32'h74);
      rd(8'h00, d);  chk("R10 no source step", d, 32'h02);
      rd(8'h18, c1);
      idle(8);
      rd(8'h18, d);  chk("R10 count frozen", d, c1);
      wr(8'h40, 32'h1);
      #1 chk("R10 clear flag", err_irq, 1'b0);
   endtask

   task automatic t_nmi;
      logic [31:0] d, c1;
      wr(8'h1C, 32'h15);
      idle(3);
      @(negedge clk);
      nmi_in = 1'b1; reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h1;
      @(negedge clk);
      nmi_in = 1'b0; reg_wr = 1'b0;
      rd(8'h40, d);  chk("R11 set beats clear", d, 32'h3);
      rd(8'h1C, d);  chk("R11 channel enable dropped", d, 32'h14);
      rd(8'h18, c1);
      idle(8);
      rd(8'h18, d);  chk("R11 count frozen", d, c1);
      wr(8'h40, 32'h1);
      rd(8'h40, d);  chk("R11 cleared", d, 32'h1);
   endtask

   task automatic t_clear;
      logic [31:0] d, c1;
      wr(8'h10, 32'h44);
      rd(8'h18, c1);
      wr(8'h44, 32'h1);
      rd(8'h00, d); chk("R12 src0 zeroed", d, 0);
      rd(8'h0C, d); chk("R12 ctl0 zeroed", d, 0);
      rd(8'h10, d); chk("R12 src1 kept", d, 32'h44);
      rd(8'h18, d); chk("R12 cnt1 kept", d, c1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? pat(i) : 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regmap;
      wr(8'h40, 32'h1);
      t_copy;
      t_size;
      t_rr;
      t_preq;
      t_zero;
      t_aerr;
      t_nmi;
      t_clear;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule